// File: doc/BRIEF.md
# CPU Interrupt and Reset Sequencer

This block sits in front of the fetch stage of an 8-bit CPU core. The core marks each instruction boundary with a strobe. At that strobe the sequencer picks one pending event and services it. The event can be a reset request, a non-maskable interrupt, or a maskable interrupt taken in the single supported vectored mode. For the chosen event the sequencer tells the core whether to call a vector and at which address. It also says how many extra cycles the entry costs and whether the register file must be cleared.

The sequencer also owns the two interrupt-enable flip-flops, the halt flag and the one-instruction shadow that follows an enable-interrupts instruction. The core reports enable, disable and halt instructions as one-cycle command pulses. A running total of all entry costs is kept in a wide counter that wraps silently.

Top module: `evt_seq`

## Requirements
- R1: Events are serviced only in a cycle where `boundary` is high, in fixed priority reset > NMI > maskable interrupt, and at most one per boundary. The results (`take_vector`, `vector_addr`, `extra_cycles`, `reg_reset`, `mode_err`) show in the cycle after that boundary edge, for one cycle. When no event is serviced they are all zero.
- R2: A serviced reset pulses `reg_reset`, raises no `take_vector` and reports 3 extra cycles. It clears a pending NMI along with its own request, and it clears both enable flags and the halt flag.
- R3: A serviced NMI calls vector 0x0066 with 11 extra cycles. It copies `iff1` into `iff2`, clears `iff1` and clears the halt flag.
- R4: A maskable interrupt is considered only while `irq_line` is high, `iff1` is set, and no `ei_cmd` has arrived since the previous boundary. An `ei_cmd` therefore blocks the very next boundary.
- R5: A maskable interrupt accepted with `int_mode` = 2'd1 calls vector 0x0038 with 13 extra cycles. It clears `iff1`, `iff2` and the halt flag.
- R6: `reset_req` and `nmi_req` pulses stay pending until serviced, however many cycles pass first. `irq_line` is not latched: a level that falls before a boundary causes nothing.
- R7: `halted` is high only while the halt flag (set by `halt_cmd`) is set and no reset, NMI or maskable request is pending or present.
- R8: A maskable interrupt that would be accepted while `int_mode` is 2'd0, 2'd2 or 2'd3 pulses `mode_err`. It takes no vector, adds 0 cycles and leaves `iff1` and `iff2` unchanged.
- R9: `cycle_count` accumulates every reported `extra_cycles` value modulo 2^CYC_W.
- R10: `ei_cmd` sets both `iff1` and `iff2`. `di_cmd` clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| reset_req | input | 1 | Core reset request pulse, latched |
| nmi_req | input | 1 | Non-maskable interrupt request pulse, latched |
| irq_line | input | 1 | Maskable interrupt level |
| boundary | input | 1 | Instruction boundary strobe |
| ei_cmd | input | 1 | Enable-interrupts instruction executed |
| di_cmd | input | 1 | Disable-interrupts instruction executed |
| halt_cmd | input | 1 | Halt instruction executed |
| int_mode | input | 2 | Current maskable interrupt mode (1 is supported) |
| take_vector | output | 1 | Core must perform a subroutine call |
| vector_addr | output | ADDR_W | Target of the call |
| extra_cycles | output | 4 | Cycle cost of the serviced entry |
| reg_reset | output | 1 | Core must reset its register file |
| mode_err | output | 1 | Maskable interrupt hit an unsupported mode |
| halted | output | 1 | Core is halted |
| iff1 | output | 1 | Primary interrupt-enable flag |
| iff2 | output | 1 | Secondary interrupt-enable flag |
| cycle_count | output | CYC_W | Running total of entry costs |

## Verification
The assertions assume the core respects the command protocol. `ei_cmd`, `di_cmd` and `halt_cmd` never arrive in a boundary cycle, and `int_mode` is steady around a boundary. The bench pulses every command in its own cycle between boundaries and changes the mode only while no boundary is pending. It drives all inputs at the falling edge, so each boundary sees settled values. A second instance with a 5-bit counter shares the stimulus so that wrap-around is reached quickly.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_RST,
    EV_NMI,
    EV_IRQ,
    EV_BAD
  } evt_e;

  localparam int COST_RST = 3;
  localparam int COST_NMI = 11;
  localparam int COST_IRQ = 13;
  localparam int COST_W   = $clog2(COST_IRQ + 1);
  localparam logic [1:0] MODE_VECTORED = 2'd1;

  function automatic logic [COST_W-1:0] evt_cost(evt_e e);
    case (e)
      EV_RST:  return COST_W'(COST_RST);
      EV_NMI:  return COST_W'(COST_NMI);
      EV_IRQ:  return COST_W'(COST_IRQ);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/evt_pend_latch.sv
module evt_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_req,
  input  logic nmi_req,
  input  logic clr_rst,
  input  logic clr_nmi,
  output logic pend_rst,
  output logic pend_nmi,
  output logic rst_eff,
  output logic nmi_eff
);
  assign rst_eff = pend_rst | reset_req;
  assign nmi_eff = pend_nmi | nmi_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_rst <= 1'b0;
      pend_nmi <= 1'b0;
    end else begin
      pend_rst <= rst_eff & ~clr_rst;
      pend_nmi <= nmi_eff & ~clr_nmi;
    end
  end
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import evt_seq_pkg::*;
(
  input  logic       boundary,
  input  logic       rst_eff,
  input  logic       nmi_eff,
  input  logic       irq_line,
  input  logic       iff1,
  input  logic       just_en,
  input  logic [1:0] int_mode,
  output evt_e       ev
);
  always_comb begin
    ev = EV_NONE;
    if (boundary) begin
      if (rst_eff)                          ev = EV_RST;
      else if (nmi_eff)                     ev = EV_NMI;
      else if (irq_line && iff1 && !just_en)
        ev = (int_mode == MODE_VECTORED) ? EV_IRQ : EV_BAD;
    end
  end
endmodule

// File: rtl/evt_flags.sv
module evt_flags
  import evt_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_e ev,
  input  logic boundary,
  input  logic ei_cmd,
  input  logic di_cmd,
  input  logic halt_cmd,
  output logic iff1,
  output logic iff2,
  output logic just_en,
  output logic halt_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iff1      <= 1'b0;
      iff2      <= 1'b0;
      just_en   <= 1'b0;
      halt_flag <= 1'b0;
    end else begin
      case (ev)
        EV_RST: begin
          iff1 <= 1'b0; iff2 <= 1'b0; just_en <= 1'b0; halt_flag <= 1'b0;
        end
        EV_NMI: begin
          iff2 <= iff1; iff1 <= 1'b0; just_en <= 1'b0; halt_flag <= 1'b0;
        end
        EV_IRQ: begin
          iff1 <= 1'b0; iff2 <= 1'b0; just_en <= 1'b0; halt_flag <= 1'b0;
        end
        default: begin
          if (di_cmd) begin
            iff1 <= 1'b0; iff2 <= 1'b0;
          end
          if (ei_cmd) begin
            iff1 <= 1'b1; iff2 <= 1'b1;
          end
          if (halt_cmd) halt_flag <= 1'b1;
          if (ei_cmd)        just_en <= 1'b1;
          else if (boundary) just_en <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cyc_accum.sv
module cyc_accum #(
  parameter int CYC_W = 64,
  parameter int ADD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADD_W-1:0] add,
  output logic [CYC_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + CYC_W'(add);
  end
endmodule

// File: rtl/evt_seq.sv
module evt_seq
  import evt_seq_pkg::*;
#(
  parameter int               ADDR_W  = 16,
  parameter int               CYC_W   = 64,
  parameter logic [ADDR_W-1:0] NMI_VEC = ADDR_W'(16'h0066),
  parameter logic [ADDR_W-1:0] IRQ_VEC = ADDR_W'(16'h0038)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_req,
  input  logic              nmi_req,
  input  logic              irq_line,
  input  logic              boundary,
  input  logic              ei_cmd,
  input  logic              di_cmd,
  input  logic              halt_cmd,
  input  logic [1:0]        int_mode,
  output logic              take_vector,
  output logic [ADDR_W-1:0] vector_addr,
  output logic [3:0]        extra_cycles,
  output logic              reg_reset,
  output logic              mode_err,
  output logic              halted,
  output logic              iff1,
  output logic              iff2,
  output logic [CYC_W-1:0]  cycle_count
);
  evt_e ev;
  logic pend_rst, pend_nmi, rst_eff, nmi_eff;
  logic just_en, halt_flag;
  logic [COST_W-1:0] cost_now;

  function automatic logic [ADDR_W-1:0] vec_of(evt_e e);
    case (e)
      EV_NMI:  return NMI_VEC;
      EV_IRQ:  return IRQ_VEC;
      default: return '0;
    endcase
  endfunction

  assign cost_now = evt_cost(ev);

  evt_pend_latch u_pend (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_req(nmi_req),
    .clr_rst(ev == EV_RST), .clr_nmi(ev == EV_RST || ev == EV_NMI),
    .pend_rst(pend_rst), .pend_nmi(pend_nmi),
    .rst_eff(rst_eff), .nmi_eff(nmi_eff)
  );

  evt_arbiter u_arb (
    .boundary(boundary), .rst_eff(rst_eff), .nmi_eff(nmi_eff),
    .irq_line(irq_line), .iff1(iff1), .just_en(just_en),
    .int_mode(int_mode), .ev(ev)
  );

  evt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ev(ev), .boundary(boundary),
    .ei_cmd(ei_cmd), .di_cmd(di_cmd), .halt_cmd(halt_cmd),
    .iff1(iff1), .iff2(iff2), .just_en(just_en), .halt_flag(halt_flag)
  );

  cyc_accum #(.CYC_W(CYC_W), .ADD_W(COST_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .add(cost_now), .count(cycle_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_vector  <= 1'b0;
      vector_addr  <= '0;
      extra_cycles <= '0;
      reg_reset    <= 1'b0;
      mode_err     <= 1'b0;
    end else begin
      take_vector  <= (ev == EV_NMI) || (ev == EV_IRQ);
      vector_addr  <= vec_of(ev);
      extra_cycles <= cost_now;
      reg_reset    <= (ev == EV_RST);
      mode_err     <= (ev == EV_BAD);
    end
  end

  assign halted = halt_flag & ~(pend_rst | pend_nmi | irq_line);
endmodule

// File: rtl/evt_seq_chk.sv
module evt_seq_chk
  import evt_seq_pkg::*;
#(
  parameter int               ADDR_W  = 16,
  parameter int               CYC_W   = 64,
  parameter logic [ADDR_W-1:0] NMI_VEC = '0,
  parameter logic [ADDR_W-1:0] IRQ_VEC = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary,
  input logic              irq_line,
  input evt_e              ev,
  input logic              just_en,
  input logic              iff1,
  input logic              iff2,
  input logic              take_vector,
  input logic [ADDR_W-1:0] vector_addr,
  input logic [3:0]        extra_cycles,
  input logic              reg_reset,
  input logic              mode_err,
  input logic              halted,
  input logic [CYC_W-1:0]  cycle_count
);
  assert_quiet_off_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> !take_vector && !reg_reset && !mode_err && extra_cycles == 4'd0);

  assert_reset_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_RST |=> reg_reset && !take_vector && extra_cycles == 4'd3 && !iff1 && !iff2);

  assert_nmi_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_NMI |=> take_vector && vector_addr == NMI_VEC && extra_cycles == 4'd11
                     && !iff1 && iff2 == $past(iff1));

  assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_IRQ |-> irq_line && iff1 && !just_en);

  assert_irq_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_IRQ |=> take_vector && vector_addr == IRQ_VEC && extra_cycles == 4'd13
                     && !iff1 && !iff2);

  assert_halt_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !irq_line);

  assert_bad_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_BAD |=> mode_err && !take_vector && extra_cycles == 4'd0
                     && iff1 == $past(iff1) && iff2 == $past(iff2));

  assert_cycle_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cycle_count == $past(cycle_count) + CYC_W'(extra_cycles));
endmodule

bind evt_seq evt_seq_chk #(
  .ADDR_W(ADDR_W), .CYC_W(CYC_W), .NMI_VEC(NMI_VEC), .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .irq_line(irq_line),
  .ev(ev), .just_en(just_en), .iff1(iff1), .iff2(iff2),
  .take_vector(take_vector), .vector_addr(vector_addr),
  .extra_cycles(extra_cycles), .reg_reset(reg_reset), .mode_err(mode_err),
  .halted(halted), .cycle_count(cycle_count)
);

// File: tb/evt_seq_test.sv
`timescale 1ns/1ps
module evt_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_req = 0, nmi_req = 0, irq_line = 0, boundary = 0;
  logic ei_cmd = 0, di_cmd = 0, halt_cmd = 0;
  logic [1:0] int_mode = 2'd1;

  logic        take_vector, reg_reset, mode_err, halted, iff1, iff2;
  logic [15:0] vector_addr;
  logic [3:0]  extra_cycles;
  logic [63:0] cycle_count;

  logic        s_tv, s_rr, s_me, s_h, s_i1, s_i2;
  logic [15:0] s_va;
  logic [3:0]  s_ec;
  logic [4:0]  s_cnt;

  int checks = 0;
  int fails = 0;
  logic [63:0] exp_cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_seq uut (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_req(nmi_req),
    .irq_line(irq_line), .boundary(boundary), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
    .halt_cmd(halt_cmd), .int_mode(int_mode), .take_vector(take_vector),
    .vector_addr(vector_addr), .extra_cycles(extra_cycles), .reg_reset(reg_reset),
    .mode_err(mode_err), .halted(halted), .iff1(iff1), .iff2(iff2),
    .cycle_count(cycle_count)
  );

  evt_seq #(.CYC_W(5)) uut_small (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_req(nmi_req),
    .irq_line(irq_line), .boundary(boundary), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
    .halt_cmd(halt_cmd), .int_mode(int_mode), .take_vector(s_tv),
    .vector_addr(s_va), .extra_cycles(s_ec), .reg_reset(s_rr),
    .mode_err(s_me), .halted(s_h), .iff1(s_i1), .iff2(s_i2),
    .cycle_count(s_cnt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(posedge clk); #1 sig = 1'b0;
  endtask

  task automatic bnd();
    @(negedge clk); boundary = 1'b1;
    @(posedge clk); #1 boundary = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic tv, input logic [15:0] va,
                            input logic [3:0] ec, input logic rr, input logic me);
    chk({req, " take_vector"}, take_vector, tv);
    chk({req, " vector_addr"}, vector_addr, va);
    chk({req, " extra_cycles"}, extra_cycles, ec);
    chk({req, " reg_reset"}, reg_reset, rr);
    chk({req, " mode_err"}, mode_err, me);
    exp_cyc += 64'(ec);
  endtask

  task automatic t_reset_state();
    expect_out("R1 reset state", 0, 16'h0, 4'd0, 0, 0);
    chk("R7 reset halted", halted, 0);
    chk("R10 reset iff1", iff1, 0);
    chk("R9 reset count", cycle_count, 0);
  endtask

  task automatic t_idle();
    bnd(); expect_out("R1 idle boundary", 0, 16'h0, 4'd0, 0, 0);
  endtask

  task automatic t_ei_shadow();
    @(negedge clk) irq_line = 1'b1;
    pulse(ei_cmd);
    chk("R10 ei iff1", iff1, 1); chk("R10 ei iff2", iff2, 1);
    bnd(); expect_out("R4 shadow after ei", 0, 16'h0, 4'd0, 0, 0);
    bnd(); expect_out("R5 irq entry", 1, 16'h0038, 4'd13, 0, 0);
    chk("R5 iff1 cleared", iff1, 0); chk("R5 iff2 cleared", iff2, 0);
    @(negedge clk) irq_line = 1'b0;
  endtask

  task automatic t_irq_disabled();
    @(negedge clk) irq_line = 1'b1;
    bnd(); expect_out("R4 irq while disabled", 0, 16'h0, 4'd0, 0, 0);
    @(negedge clk) irq_line = 1'b0;
  endtask

  task automatic t_nmi();
    pulse(ei_cmd); bnd(); expect_out("R4 shadow boundary", 0, 16'h0, 4'd0, 0, 0);
    @(negedge clk) irq_line = 1'b1;
    pulse(nmi_req);
    bnd(); expect_out("R1 R3 nmi over irq", 1, 16'h0066, 4'd11, 0, 0);
    chk("R3 iff1 cleared", iff1, 0); chk("R3 iff2 copy", iff2, 1);
    @(negedge clk) irq_line = 1'b0;
    bnd(); expect_out("R3 nmi consumed", 0, 16'h0, 4'd0, 0, 0);
  endtask

  task automatic t_reset_prio();
    pulse(nmi_req); pulse(reset_req);
    bnd(); expect_out("R1 R2 reset wins", 0, 16'h0, 4'd3, 1, 0);
    chk("R2 iff1", iff1, 0); chk("R2 iff2", iff2, 0);
    bnd(); expect_out("R2 nmi discarded", 0, 16'h0, 4'd0, 0, 0);
  endtask

  task automatic t_latch();
    pulse(nmi_req);
    repeat (5) @(posedge clk);
    #1 chk("R6 no action without boundary", take_vector, 0);
    bnd(); expect_out("R6 latched nmi", 1, 16'h0066, 4'd11, 0, 0);
    pulse(ei_cmd); bnd(); expect_out("R4 shadow", 0, 16'h0, 4'd0, 0, 0);
    pulse(irq_line);
    bnd(); expect_out("R6 irq level not latched", 0, 16'h0, 4'd0, 0, 0);
    pulse(di_cmd);
  endtask

  task automatic t_halt();
    pulse(halt_cmd);
    chk("R7 halted set", halted, 1);
    @(negedge clk) irq_line = 1'b1;
    #1 chk("R7 irq wakes", halted, 0);
    @(negedge clk) irq_line = 1'b0;
    #1 chk("R7 halted again", halted, 1);
    pulse(nmi_req);
    chk("R7 nmi pending wakes", halted, 0);
    bnd(); expect_out("R3 nmi from halt", 1, 16'h0066, 4'd11, 0, 0);
    chk("R7 halt left", halted, 0);
  endtask

  task automatic t_mode();
    @(negedge clk) int_mode = 2'd2;
    pulse(ei_cmd); bnd(); expect_out("R4 shadow", 0, 16'h0, 4'd0, 0, 0);
    @(negedge clk) irq_line = 1'b1;
    bnd(); expect_out("R8 mode 2", 0, 16'h0, 4'd0, 0, 1);
    chk("R8 iff1 kept", iff1, 1); chk("R8 iff2 kept", iff2, 1);
    @(negedge clk) int_mode = 2'd0;
    bnd(); expect_out("R8 mode 0", 0, 16'h0, 4'd0, 0, 1);
    @(negedge clk) begin irq_line = 1'b0; int_mode = 2'd1; end
  endtask

  task automatic t_di();
    @(negedge clk) irq_line = 1'b1;
    pulse(di_cmd);
    chk("R10 di iff1", iff1, 0); chk("R10 di iff2", iff2, 0);
    bnd(); expect_out("R10 irq after di", 0, 16'h0, 4'd0, 0, 0);
    @(negedge clk) irq_line = 1'b0;
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 4; i++) begin
      pulse(reset_req);
      bnd(); expect_out("R2 repeated reset", 0, 16'h0, 4'd3, 1, 0);
    end
    @(posedge clk); #1;
    chk("R9 total", cycle_count, exp_cyc);
    chk("R9 wrapped total", 64'(s_cnt), exp_cyc & 64'h1f);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_state();
    t_idle();
    t_ei_shadow();
    t_irq_disabled();
    t_nmi();
    t_reset_prio();
    t_latch();
    t_halt();
    t_mode();
    t_di();
    t_wrap();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule